// File: doc/BRIEF.md
# Unaligned Byte-Addressed Bus RAM

A small on-chip memory that responds as a Wishbone slave on a 64-bit data bus with an 8-bit lane select. The address is a byte address, and an access may begin at any byte offset. Storage is organised as 64-bit words, so an access that begins part-way into a word continues into the next word. The block reads both words and shifts the bytes it needs down to lane zero. On a write it shifts the lanes up and splits them across the two words.

A request is a cycle in which cyc and stb are both high after stb has been seen low. The block acknowledges each request on the next clock edge with a one-cycle pulse. Read data is registered alongside the acknowledge. Whenever reset is applied, the memory is loaded with a fixed pattern in which every byte holds the low eight bits of its own address, so tests need no preload. Byte addresses fold modulo the capacity, and an access that runs past the top byte continues at byte 0.

Top module: `ulram`

## Requirements
- R1: While rst is high, ack stays low whatever cyc and stb do, and it is low in the first cycle after rst falls.
- R2: ack is low in the cycle in which a request is first presented and high in the following cycle.
- R3: ack is high for exactly one cycle per request. If stb is held high it does not fire again, and ack is low one cycle after stb drops.
- R4: A read returns eight consecutive bytes. The byte at the request address is in bits 7:0, and each following address fills the next higher lane (address+k in bits 8k+7:8k). The select value (0x01, 0x03, 0x0F or 0xFF for 1, 2, 4 or 8 bytes) does not change what is returned.
- R5: After reset, the byte at address a holds a modulo 256.
- R6: A read whose bytes lie in two storage words, such as 8 bytes at address 7, returns the bytes of both words in address order.
- R7: A write stores select lane k (bits 8k+7:8k) into byte address+k, only for set select bits. Bytes whose select bit is clear are not changed, and a write leaves the read-data output unchanged.
- R8: A write that spans two storage words reads back identically at the same address.
- R9: Byte addresses fold modulo MEM_BYTES. An access that runs past byte MEM_BYTES-1 continues at byte 0, and no error is raised.
- R10: Applying reset again restores the pattern of R5 and discards earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; reloads the pattern |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe; a request when high with cyc after being seen low |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_sel | input | 8 | Lane select; lane k maps to byte address+k |
| wb_adr | input | ADDR_W | Byte address of the first byte |
| wb_dat_w | input | 64 | Write data, packed from lane 0 |
| wb_dat_r | output | 64 | Read data, packed from lane 0, valid with ack |
| wb_ack | output | 1 | One-cycle acknowledge |

## Verification
The bench builds the block with MEM_BYTES = 16 and ADDR_W = 64, which gives exactly two storage words. At this size, every access at offset 1 to 7 spans both words, and an access near byte 15 also wraps to word 0. The bench also uses addresses above 15 to exercise address folding. Select patterns that are not runs of low lanes show that only the selected bytes are written.

// File: rtl/ulram_pkg.sv
package ulram_pkg;
  localparam int LANES  = 8;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef logic [DATA_W-1:0]   word_t;
  typedef logic [2*DATA_W-1:0] pair_t;
  typedef logic [LANES-1:0]    lanes_t;
  typedef logic [2*LANES-1:0]  pair_lanes_t;
  typedef logic [2:0]          off_t;

  // Power-up pattern: each byte equals the low bits of its own address.
  function automatic word_t pattern_word(int unsigned widx);
    word_t w;
    for (int i = 0; i < LANES; i++) begin
      w[i*BYTE_W +: BYTE_W] = BYTE_W'(widx * LANES + i);
    end
    return w;
  endfunction

  // Pull the eight bytes starting at 'off' out of two adjacent words.
  function automatic word_t gather(word_t lo, word_t hi, off_t off);
    pair_t p;
    p = {hi, lo} >> (32'(off) * BYTE_W);
    return p[DATA_W-1:0];
  endfunction

  // Move lane-0 packed write data up to its byte offset in a word pair.
  function automatic pair_t spread_data(word_t d, off_t off);
    return pair_t'(d) << (32'(off) * BYTE_W);
  endfunction

  function automatic pair_lanes_t spread_mask(lanes_t s, off_t off);
    return pair_lanes_t'(s) << off;
  endfunction
endpackage

// File: rtl/ulram_handshake.sv
module ulram_handshake (
  input  logic clk,
  input  logic rst,
  input  logic cyc,
  input  logic stb,
  output logic fire,
  output logic ack
);
  logic busy_q;

  // A request is taken only once stb has been observed low since the last one.
  assign fire = cyc && stb && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ack    <= 1'b0;
    end else begin
      ack <= fire;
      if (fire)      busy_q <= 1'b1;
      else if (!stb) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ulram_align.sv
module ulram_align
  import ulram_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int WIDX_W = 1
) (
  input  logic [ADDR_W-1:0] adr,
  input  lanes_t            sel,
  input  word_t             wdat,
  input  word_t             rd_lo,
  input  word_t             rd_hi,
  output logic [WIDX_W-1:0] widx_lo,
  output logic [WIDX_W-1:0] widx_hi,
  output pair_lanes_t       wmask,
  output pair_t             wdata,
  output word_t             rd_word
);
  off_t off;
  logic unused_adr_hi;

  assign off     = adr[2:0];
  assign widx_lo = adr[3 +: WIDX_W];
  assign widx_hi = WIDX_W'(widx_lo + 1'b1);   // folds past the top word
  assign unused_adr_hi = ^adr[ADDR_W-1:3+WIDX_W];

  assign wmask   = spread_mask(sel, off);
  assign wdata   = spread_data(wdat, off);
  assign rd_word = gather(rd_lo, rd_hi, off);
endmodule

// File: rtl/ulram_store.sv
module ulram_store
  import ulram_pkg::*;
#(
  parameter int NWORDS = 2,
  parameter int WIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [WIDX_W-1:0] widx_lo,
  input  logic [WIDX_W-1:0] widx_hi,
  input  pair_lanes_t       wmask,
  input  pair_t             wdata,
  output word_t             rd_lo,
  output word_t             rd_hi
);
  word_t words [NWORDS];

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    word_t word_q;
    logic  hit_lo, hit_hi;

    assign hit_lo = wr_fire && (widx_lo == WIDX_W'(j));
    assign hit_hi = wr_fire && (widx_hi == WIDX_W'(j));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= pattern_word(j);
      end else begin
        for (int b = 0; b < LANES; b++) begin
          if (hit_lo && wmask[b])
            word_q[b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
          else if (hit_hi && wmask[LANES+b])
            word_q[b*BYTE_W +: BYTE_W] <= wdata[DATA_W + b*BYTE_W +: BYTE_W];
        end
      end
    end

    assign words[j] = word_q;
  end

  assign rd_lo = words[widx_lo];
  assign rd_hi = words[widx_hi];
endmodule

// File: rtl/ulram.sv
module ulram
  import ulram_pkg::*;
#(
  parameter int MEM_BYTES = 16,   // power of two, at least two words
  parameter int ADDR_W    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [7:0]        wb_sel,
  input  logic [ADDR_W-1:0] wb_adr,
  input  logic [63:0]       wb_dat_w,
  output logic [63:0]       wb_dat_r,
  output logic              wb_ack
);
  localparam int NWORDS = MEM_BYTES / LANES;
  localparam int WIDX_W = $clog2(NWORDS);

  logic              acc_fire;
  logic              wr_fire;
  logic [WIDX_W-1:0] widx_lo, widx_hi;
  pair_lanes_t       wmask;
  pair_t             wdata;
  word_t             rd_lo, rd_hi, rd_word;
  word_t             rdata_q;

  ulram_handshake u_hs (
    .clk (clk), .rst (rst), .cyc (wb_cyc), .stb (wb_stb),
    .fire(acc_fire), .ack (wb_ack)
  );

  ulram_align #(.ADDR_W(ADDR_W), .WIDX_W(WIDX_W)) u_align (
    .adr    (wb_adr),  .sel    (wb_sel),  .wdat (wb_dat_w),
    .rd_lo  (rd_lo),   .rd_hi  (rd_hi),
    .widx_lo(widx_lo), .widx_hi(widx_hi),
    .wmask  (wmask),   .wdata  (wdata),   .rd_word(rd_word)
  );

  assign wr_fire = acc_fire && wb_we;

  ulram_store #(.NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_store (
    .clk    (clk),     .rst    (rst),     .wr_fire(wr_fire),
    .widx_lo(widx_lo), .widx_hi(widx_hi),
    .wmask  (wmask),   .wdata  (wdata),
    .rd_lo  (rd_lo),   .rd_hi  (rd_hi)
  );

  always_ff @(posedge clk) begin
    if (rst)                    rdata_q <= '0;
    else if (acc_fire && !wb_we) rdata_q <= rd_word;
  end

  assign wb_dat_r = rdata_q;
endmodule

// File: rtl/ulram_checker.sv
module ulram_checker (
  input logic        clk,
  input logic        rst,
  input logic        cyc,
  input logic        stb,
  input logic        we,
  input logic        ack,
  input logic        fire,
  input logic [63:0] dat_r
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !ack);

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    fire |=> ack);

  assert_ack_has_req_R2: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(cyc && stb));

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_no_refire_R3: assert property (@(posedge clk) disable iff (rst)
    (ack && stb) |-> !fire);

  assert_write_keeps_rdata_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && we) |=> $stable(dat_r));
endmodule

bind ulram ulram_checker chk (
  .clk(clk), .rst(rst), .cyc(wb_cyc), .stb(wb_stb), .we(wb_we),
  .ack(wb_ack), .fire(acc_fire), .dat_r(wb_dat_r)
);

// File: tb/ulram_test.sv
module ulram_test;
  localparam int  CLK_P = 10;
  localparam int  MEMB  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [7:0]  wb_sel = '0;
  logic [63:0] wb_adr = '0;
  logic [63:0] wb_dat_w = '0;
  logic [63:0] wb_dat_r;
  logic        wb_ack;

  int total = 0, bad = 0, ack_seen = 0;
  bit finished = 0;
  logic [7:0]  model [MEMB];
  logic [63:0] exp_q [$];
  bit          rd_q  [$];
  string       tag_q [$];

  ulram #(.MEM_BYTES(MEMB), .ADDR_W(64)) uut (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_sel(wb_sel), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w),
    .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < MEMB; i++) model[i] = 8'(i);
  endfunction

  function automatic logic [63:0] model_read(logic [63:0] a);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = model[int'((a + 64'(k)) % 64'(MEMB))];
    return r;
  endfunction

  function automatic void model_write(logic [63:0] a, logic [7:0] s, logic [63:0] d);
    for (int k = 0; k < 8; k++)
      if (s[k]) model[int'((a + 64'(k)) % 64'(MEMB))] = d[k*8 +: 8];
  endfunction

  // Monitor: every acknowledge is matched against the scoreboard queue.
  always @(negedge clk) begin
    if (wb_ack) begin
      ack_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected ack", 64'(wb_ack), 64'd0);
      end else begin
        logic [63:0] e;
        bit          isrd;
        string       t;
        e = exp_q.pop_front(); isrd = rd_q.pop_front(); t = tag_q.pop_front();
        if (isrd) check(wb_dat_r === e, t, wb_dat_r, e);
      end
    end
  end

  // Driver: one request, with the handshake timing of R2 and R3 checked here.
  task automatic access(bit we, logic [7:0] s, logic [63:0] a, logic [63:0] d, string tag);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_sel = s; wb_adr = a; wb_dat_w = d;
    exp_q.push_back(we ? 64'd0 : model_read(a)); rd_q.push_back(!we); tag_q.push_back(tag);
    if (we) model_write(a, s, d);
    check(wb_ack == 1'b0, "R2 ack low on first cycle", 64'(wb_ack), 64'd0);
    @(negedge clk);
    check(wb_ack == 1'b1, "R2 ack next cycle", 64'(wb_ack), 64'd1);
    wb_stb = 0; wb_cyc = 0;
    @(negedge clk);
    check(wb_ack == 1'b0, "R3 ack low after stb drop", 64'(wb_ack), 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      check(0, "watchdog expired", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    model_reset();
    // R1: requests presented during reset get no acknowledge
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_sel = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(wb_ack == 1'b0, "R1 no ack in reset", 64'(wb_ack), 64'd0);
    end
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(wb_ack == 1'b0, "R1 ack low after reset", 64'(wb_ack), 64'd0);

    // R4 R5: pattern reads of every size at offsets 0, 1, 7
    access(0, 8'h01, 64'd0, '0, "R5 pattern byte 0");
    access(0, 8'h01, 64'd1, '0, "R4 sel 0x01 at 1");
    access(0, 8'h03, 64'd7, '0, "R4 sel 0x03 at 7");
    access(0, 8'h0F, 64'd1, '0, "R4 sel 0x0F at 1");
    access(0, 8'hFF, 64'd0, '0, "R5 eight bytes at 0");
    // R6: reads gathering two words
    access(0, 8'hFF, 64'd7, '0, "R6 eight bytes at 7");
    access(0, 8'h0F, 64'd6, '0, "R6 four bytes at 6");

    // R7: single lane and sparse lane writes
    access(1, 8'h01, 64'd0, 64'hFFFF_FFFF_FFFF_FF0F, "R7 byte write");
    access(0, 8'hFF, 64'd0, '0, "R7 only byte 0 changed");
    access(1, 8'h05, 64'd3, 64'h1122_3344_55AA_66BB, "R7 sparse write");
    access(0, 8'hFF, 64'd0, '0, "R7 lanes 3 and 5 only");

    // R8: write spanning two words, then read back
    access(1, 8'hFF, 64'd7, 64'hBADC_0FFE_BADC_0FFE, "R8 spanning write");
    access(0, 8'hFF, 64'd7, '0, "R8 spanning readback");
    access(0, 8'hFF, 64'd8, '0, "R8 upper word view");

    // R9: folding and wrap past the top byte
    access(0, 8'hFF, 64'd17, '0, "R9 alias of 1");
    access(0, 8'hFF, 64'd13, '0, "R9 read wraps to 0");
    access(1, 8'hFF, 64'd15, 64'h0102_0304_0506_0708, "R9 write wraps");
    access(0, 8'hFF, 64'd31, '0, "R9 read via alias 31");
    access(0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFF8, '0, "R9 high address");

    // R3: holding stb high gives one acknowledge only
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_sel = 8'hFF; wb_adr = 64'd2;
    exp_q.push_back(model_read(64'd2)); rd_q.push_back(1); tag_q.push_back("R3 held read data");
    base = ack_seen;
    repeat (5) @(negedge clk);
    check(ack_seen == base + 1, "R3 one ack while stb held", 64'(ack_seen - base), 64'd1);
    wb_stb = 0; wb_cyc = 0;
    @(negedge clk);
    check(wb_ack == 1'b0, "R3 ack low after hold", 64'(wb_ack), 64'd0);

    // R10: reset again restores the pattern
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    access(0, 8'hFF, 64'd0, '0, "R10 pattern word 0 restored");
    access(0, 8'hFF, 64'd8, '0, "R10 pattern word 1 restored");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 all requests acknowledged", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule